// File: doc/BRIEF.md
# Microop Integer ALU with Size-Merge

This block is the execute stage for register-to-register integer microops. Each cycle it can take one microop: an opcode, the old value of the destination register, two source values, an 8-bit immediate, an operand size of 1, 2, 4 or 8 bytes, a per-flag write mask and an optional condition. One clock edge later it presents the merged destination value and the updated condition flags.

Only the low bytes selected by the operand size are replaced. All bits above them keep the old destination value. A move instead takes its upper bits from source 1.

The second operand is either source 2 or the zero-extended immediate. The flag-writing form updates only the flags chosen by the mask. The conditional form tests a 4-bit condition against the flags the block currently holds. When the condition fails, both the destination and the flags are left untouched.

Flags are kept in a state register inside the block. This register supplies the carry input to add-with-carry and subtract-with-borrow, and it is the value the condition is tested against. The decoder ahead of the block sees only the results on the output ports.

Top module: `uop_alu_exec`

## Requirements
- R1: With `size_sel` = 0, 1, 2 or 3, the operation works on 1, 2, 4 or 8 bytes. `dest_new` takes the low bytes of that width from the result, and every bit above them equals the bit in `dest_old` (except for MOV, see R5).
- R2: When `imm_sel` = 1, the second operand is `imm8` zero-extended to 64 bits. When `imm_sel` = 0, it is `src2`. Nothing else about the operation changes.
- R3: Opcodes 0..6 are ADD (src1+op2), OR, ADC (src1+op2+CF), SBB (src1-op2-CF), AND, SUB (src1-op2) and XOR. CF here is the carry flag held in the block before the operation.
- R4: Opcode 7 (MUL) multiplies `dest_old` by op2 and keeps the low bytes of the product at the operand width. `src1` is not used.
- R5: Opcode 8 (MOV) builds its result from the low width bytes of op2 and the bits of `src1` above them. MOV never changes the flags.
- R6: Flag bit positions are CF=0, PF=1, AF=2, ZF=3, SF=4, OF=5, and every flag is computed at the operand width:
  - ZF is set when the width result is zero.
  - SF is the top bit of the width result.
  - PF is set when the low result byte has an even number of ones.
  - AF is bit 4 of src1^op2^result.
  - For ADD/ADC, CF is the carry out and OF the signed overflow.
  - For SUB/SBB, CF is the borrow and OF the signed overflow of the subtraction.
  - OR, AND, XOR and MUL clear CF, OF and AF.
- R7: After a committed non-MOV operation, each flag whose bit in `flag_mask` is 1 takes its newly computed value. Each flag whose mask bit is 0 keeps its value.
- R8: When `cond_en` = 1, the operation commits only if condition `cond_code` holds on the current flags. The conditions are:

  | `cond_code[3:1]` | Condition |
  |---|---|
  | 0 | OF |
  | 1 | CF |
  | 2 | ZF |
  | 3 | CF or ZF |
  | 4 | SF |
  | 5 | PF |
  | 6 | SF xor OF |
  | 7 | ZF or (SF xor OF) |

  `cond_code[0]` = 1 inverts the condition. An operation that does not commit gives `dest_new` = `dest_old`, leaves the flags unchanged and sets `committed` = 0.
- R9: `out_valid`, `dest_new` and `committed` are updated at the clock edge that samples `in_valid` = 1, so they are seen one cycle after the microop is presented. With `in_valid` = 0, `out_valid` is 0 in the next cycle and the flags do not change.
- R10: Opcodes 9..15 do not commit. `dest_new` = `dest_old`, the flags are unchanged and `committed` = 0.
- R11: Synchronous active-high reset clears `out_valid`, `committed`, `dest_new` and `flags` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A microop is presented this cycle |
| op | input | 4 | Opcode (R3, R4, R5, R10) |
| size_sel | input | 2 | Operand width: 1, 2, 4 or 8 bytes |
| imm_sel | input | 1 | 1 selects the immediate as second operand |
| imm8 | input | 8 | Immediate operand |
| dest_old | input | 64 | Current destination register value |
| src1 | input | 64 | First source |
| src2 | input | 64 | Second source (register form) |
| flag_mask | input | 6 | Per-flag write enable |
| cond_en | input | 1 | Conditional form: gate the write on `cond_code` |
| cond_code | input | 4 | Condition selector |
| out_valid | output | 1 | Result valid |
| dest_new | output | 64 | Merged destination value |
| committed | output | 1 | The microop took effect |
| flags | output | 6 | Current condition flags |

## Verification
The assertions check on every cycle:
- Bits above the operand width survive every non-MOV operation.
- Unmasked flags never change.
- MOV leaves the flags stable.
- An operation that does not commit returns `dest_old` unchanged.
- `out_valid` tracks `in_valid` with one cycle of delay.

Only the bench's scenarios can show that the arithmetic values are right. These include carry and borrow chaining across ADC and SBB, and overflow and auxiliary carry at each width. They also cover the mapping of each condition code to its flags.

// File: rtl/uop_alu_pkg.sv
package uop_alu_pkg;
  localparam int XLEN    = 64;
  localparam int NFLAGS  = 6;
  localparam int OPW     = 4;

  localparam int FL_CF = 0;
  localparam int FL_PF = 1;
  localparam int FL_AF = 2;
  localparam int FL_ZF = 3;
  localparam int FL_SF = 4;
  localparam int FL_OF = 5;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_OR  = 4'd1,
    OP_ADC = 4'd2,
    OP_SBB = 4'd3,
    OP_AND = 4'd4,
    OP_SUB = 4'd5,
    OP_XOR = 4'd6,
    OP_MUL = 4'd7,
    OP_MOV = 4'd8
  } uop_e;

  function automatic logic [XLEN-1:0] width_mask(input logic [1:0] sz);
    int w;
    w = 8 << sz;
    return {XLEN{1'b1}} >> (XLEN - w);
  endfunction
endpackage

// File: rtl/uop_arith_unit.sv
module uop_arith_unit
  import uop_alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [OPW-1:0] op,
  input  logic [1:0]     size_sel,
  input  logic [W-1:0]   src1,
  input  logic [W-1:0]   dest_old,
  input  logic [W-1:0]   op2,
  input  logic           cf_in,
  output logic [W-1:0]   raw,
  output logic [W-1:0]   opnd_a,
  output logic [W-1:0]   opnd_b,
  output logic           carry,
  output logic           is_sub,
  output logic           is_logic
);
  logic [W-1:0] m;
  logic [W-1:0] am, bm;
  logic [W:0]   sum_ext, dif_ext;
  logic         cin;
  int           wbits;

  always_comb begin
    m       = width_mask(size_sel);
    wbits   = 8 << size_sel;
    opnd_a  = (op == OP_MUL) ? dest_old : src1;
    opnd_b  = op2;
    am      = opnd_a & m;
    bm      = opnd_b & m;
    cin     = ((op == OP_ADC) || (op == OP_SBB)) ? cf_in : 1'b0;
    sum_ext = {1'b0, am} + {1'b0, bm} + {{W{1'b0}}, cin};
    dif_ext = {1'b0, am} - {1'b0, bm} - {{W{1'b0}}, cin};
    is_sub  = (op == OP_SUB) || (op == OP_SBB);
    is_logic = (op == OP_OR) || (op == OP_AND) || (op == OP_XOR) || (op == OP_MUL);
    carry   = 1'b0;
    raw     = '0;
    case (op)
      OP_ADD, OP_ADC: begin raw = sum_ext[W-1:0]; carry = sum_ext[wbits]; end
      OP_SUB, OP_SBB: begin raw = dif_ext[W-1:0]; carry = dif_ext[wbits]; end
      OP_OR:  raw = opnd_a | opnd_b;
      OP_AND: raw = opnd_a & opnd_b;
      OP_XOR: raw = opnd_a ^ opnd_b;
      OP_MUL: raw = opnd_a * opnd_b;
      OP_MOV: raw = opnd_b;
      default: raw = '0;
    endcase
  end
endmodule

// File: rtl/uop_flag_gen.sv
module uop_flag_gen
  import uop_alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [1:0]        size_sel,
  input  logic [W-1:0]      raw,
  input  logic [W-1:0]      opnd_a,
  input  logic [W-1:0]      opnd_b,
  input  logic              carry,
  input  logic              is_sub,
  input  logic              is_logic,
  output logic [NFLAGS-1:0] gen
);
  logic [W-1:0] m;
  logic         sa, sb, sr;
  int           top;

  always_comb begin
    m   = width_mask(size_sel);
    top = (8 << size_sel) - 1;
    sa  = opnd_a[top];
    sb  = opnd_b[top];
    sr  = raw[top];
    gen = '0;
    gen[FL_ZF] = ((raw & m) == '0);
    gen[FL_SF] = sr;
    gen[FL_PF] = ~(^raw[7:0]);
    if (!is_logic) begin
      gen[FL_CF] = carry;
      gen[FL_AF] = opnd_a[4] ^ opnd_b[4] ^ raw[4];
      gen[FL_OF] = is_sub ? ((sa != sb) && (sr != sa))
                          : ((sa == sb) && (sr != sa));
    end
  end
endmodule

// File: rtl/uop_cond_check.sv
module uop_cond_check
  import uop_alu_pkg::*;
(
  input  logic [NFLAGS-1:0] cur,
  input  logic [3:0]        code,
  output logic              pass
);
  logic base;
  always_comb begin
    case (code[3:1])
      3'd0: base = cur[FL_OF];
      3'd1: base = cur[FL_CF];
      3'd2: base = cur[FL_ZF];
      3'd3: base = cur[FL_CF] | cur[FL_ZF];
      3'd4: base = cur[FL_SF];
      3'd5: base = cur[FL_PF];
      3'd6: base = cur[FL_SF] ^ cur[FL_OF];
      default: base = cur[FL_ZF] | (cur[FL_SF] ^ cur[FL_OF]);
    endcase
    pass = base ^ code[0];
  end
endmodule

// File: rtl/uop_alu_exec.sv
module uop_alu_exec
  import uop_alu_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPW-1:0]    op,
  input  logic [1:0]        size_sel,
  input  logic              imm_sel,
  input  logic [7:0]        imm8,
  input  logic [W-1:0]      dest_old,
  input  logic [W-1:0]      src1,
  input  logic [W-1:0]      src2,
  input  logic [NFLAGS-1:0] flag_mask,
  input  logic              cond_en,
  input  logic [3:0]        cond_code,
  output logic              out_valid,
  output logic [W-1:0]      dest_new,
  output logic              committed,
  output logic [NFLAGS-1:0] flags
);
  logic [W-1:0]      op2, m, raw, opnd_a, opnd_b, merged;
  logic              carry, is_sub, is_logic, cond_pass, commit, is_mov;
  logic [NFLAGS-1:0] gen;

  assign op2    = imm_sel ? {{(W-8){1'b0}}, imm8} : src2;
  assign m      = width_mask(size_sel);
  assign is_mov = (op == OP_MOV);

  uop_arith_unit #(.W(W)) u_arith (
    .op(op), .size_sel(size_sel), .src1(src1), .dest_old(dest_old),
    .op2(op2), .cf_in(flags[FL_CF]), .raw(raw), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .carry(carry), .is_sub(is_sub), .is_logic(is_logic)
  );

  uop_flag_gen #(.W(W)) u_flags (
    .size_sel(size_sel), .raw(raw), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .carry(carry), .is_sub(is_sub), .is_logic(is_logic), .gen(gen)
  );

  uop_cond_check u_cond (.cur(flags), .code(cond_code), .pass(cond_pass));

  assign commit = (op <= OP_MOV) && (!cond_en || cond_pass);
  assign merged = is_mov ? ((src1 & ~m) | (raw & m))
                         : ((dest_old & ~m) | (raw & m));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      committed <= 1'b0;
      dest_new  <= '0;
      flags     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        committed <= commit;
        dest_new  <= commit ? merged : dest_old;
        if (commit && !is_mov)
          flags <= (flags & ~flag_mask) | (gen & flag_mask);
      end
    end
  end

  assert_upper_kept_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_mov) |=> ((dest_new & ~$past(m)) == ($past(dest_old) & ~$past(m))));
  assert_mov_flags_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_mov) |=> $stable(flags));
  assert_unmasked_hold_R7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((flags & ~$past(flag_mask)) == ($past(flags) & ~$past(flag_mask))));
  assert_no_commit_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (committed || (dest_new == $past(dest_old))));
  assert_valid_delay_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(flags)));
  assert_bad_op_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op > OP_MOV) |=> (!committed && $stable(flags)));
endmodule

// File: tb/sim_uop_alu_exec.sv
module sim_uop_alu_exec;
  logic clk = 0, rst = 1;
  logic in_valid = 0, imm_sel = 0, cond_en = 0;
  logic [3:0] op = 0, cond_code = 0;
  logic [1:0] size_sel = 0;
  logic [7:0] imm8 = 0;
  logic [63:0] dest_old = 0, src1 = 0, src2 = 0;
  logic [5:0] flag_mask = 0;
  logic out_valid, committed;
  logic [63:0] dest_new;
  logic [5:0] flags;

  int tests = 0, fails = 0;
  logic [5:0] mflags = 0;
  logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

  always #5 clk = ~clk;

  uop_alu_exec u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .size_sel(size_sel), .imm_sel(imm_sel), .imm8(imm8), .dest_old(dest_old),
    .src1(src1), .src2(src2), .flag_mask(flag_mask), .cond_en(cond_en),
    .cond_code(cond_code), .out_valid(out_valid), .dest_new(dest_new),
    .committed(committed), .flags(flags));

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog R9: actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit cond_true(logic [5:0] f, logic [3:0] c);
    bit cf = f[0], pf = f[1], zf = f[3], sf = f[4], of_ = f[5], b;
    unique case (c >> 1)
      0: b = of_;
      1: b = cf;
      2: b = zf;
      3: b = cf || zf;
      4: b = sf;
      5: b = pf;
      6: b = sf != of_;
      default: b = zf || (sf != of_);
    endcase
    return c[0] ? !b : b;
  endfunction

  task automatic run(string req, int o, int sz, bit isel, logic [7:0] im,
                     logic [63:0] d, logic [63:0] s1, logic [63:0] s2,
                     logic [5:0] mk, bit ce, logic [3:0] cc);
    int w;
    logic [63:0] m, b, a, r, expd, am, bm;
    logic [64:0] wide;
    logic [5:0] g;
    bit ok, cin, topbit_a, topbit_b, topbit_r;
    w = 8 * (1 << sz);
    m = (w == 64) ? '1 : ((64'd1 << w) - 1);
    b = isel ? {56'd0, im} : s2;
    a = (o == 7) ? d : s1;
    cin = mflags[0];
    am = a & m; bm = b & m;
    g = 0;
    case (o)
      0: begin wide = am + bm;         r = wide[63:0]; g[0] = (wide > {1'b0, m}); end
      2: begin wide = am + bm + cin;   r = wide[63:0]; g[0] = (wide > {1'b0, m}); end
      5: begin r = am - bm;       g[0] = (am < bm); end
      3: begin wide = bm + cin; r = am - bm - cin; g[0] = ({1'b0, am} < wide); end
      1: r = a | b;
      4: r = a & b;
      6: r = a ^ b;
      7: r = a * b;
      default: r = b;
    endcase
    topbit_a = am[w-1]; topbit_b = bm[w-1]; topbit_r = r[w-1];
    g[3] = ((r & m) == 0);
    g[4] = topbit_r;
    g[1] = ($countones(r[7:0]) % 2) == 0;
    if (o == 0 || o == 2 || o == 3 || o == 5) begin
      g[2] = a[4] ^ b[4] ^ r[4];
      if (o == 3 || o == 5) g[5] = (topbit_a != topbit_b) && (topbit_r != topbit_a);
      else                  g[5] = (topbit_a == topbit_b) && (topbit_r != topbit_a);
    end else g[0] = 0;
    ok = (o <= 8) && (!ce || cond_true(mflags, cc));
    if (!ok) expd = d;
    else if (o == 8) expd = (s1 & ~m) | (b & m);
    else expd = (d & ~m) | (r & m);
    if (ok && o != 8) mflags = (mflags & ~mk) | (g & mk);
    @(negedge clk);
    in_valid = 1; op = o[3:0]; size_sel = sz[1:0]; imm_sel = isel; imm8 = im;
    dest_old = d; src1 = s1; src2 = s2; flag_mask = mk; cond_en = ce; cond_code = cc;
    @(negedge clk);
    in_valid = 0;
    chk({req, " valid"}, {63'd0, out_valid}, 64'd1);
    chk({req, " dest"}, dest_new, expd);
    chk({req, " committed"}, {63'd0, committed}, {63'd0, ok});
    chk({req, " flags"}, {58'd0, flags}, {58'd0, mflags});
  endtask

  function automatic logic [63:0] nxt(logic [63:0] x);
    return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11 reset state
    chk("R11 out_valid", {63'd0, out_valid}, 0);
    chk("R11 dest", dest_new, 0);
    chk("R11 flags", {58'd0, flags}, 0);
    chk("R11 committed", {63'd0, committed}, 0);
    // R3 R6 byte add overflow, AF, SF
    run("R3 add8 ovf", 0, 0, 0, 0, 64'hAAAA_AAAA_AAAA_AA00, 64'h7F, 64'h1, 6'h3F, 0, 0);
    // R1 R6 carry out and zero at byte width
    run("R1 add8 carry", 0, 0, 0, 0, 64'h1111_2222_3333_4444, 64'hFF, 64'h1, 6'h3F, 0, 0);
    // R3 ADC uses CF=1
    run("R3 adc", 2, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0010, 64'h0020, 6'h3F, 0, 0);
    // R3 SUB borrow at 32 bits
    run("R3 sub borrow", 5, 2, 0, 0, 64'h5, 64'h1, 64'h2, 6'h3F, 0, 0);
    // R3 SBB consumes CF
    run("R3 sbb", 3, 2, 0, 0, 64'h9, 64'h10, 64'h3, 6'h3F, 0, 0);
    // R2 immediate zero-extended
    run("R2 or imm", 1, 3, 1, 8'hF0, 64'h0, 64'hFF00_0000_0000_000F, 64'hFFFF, 6'h3F, 0, 0);
    run("R2 xor imm", 6, 1, 1, 8'h80, 64'h0, 64'h1234_5678_8000_80FF, 64'h0, 6'h3F, 0, 0);
    run("R3 and", 4, 2, 0, 0, 64'hDEAD_BEEF_0000_0000, 64'h0F0F_F0F0, 64'h00FF_FF00, 6'h3F, 0, 0);
    // R4 MUL uses dest_old
    run("R4 mul", 7, 1, 0, 0, 64'h1234_0000_0000_0103, 64'hFFFF, 64'h0201, 6'h3F, 0, 0);
    // R6 64-bit carry
    run("R6 add64", 0, 3, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 6'h3F, 0, 0);
    // R7 only ZF written
    run("R7 mask zf", 5, 0, 0, 0, 64'h0, 64'h3, 64'h3, 6'h08, 0, 0);
    // R5 MOV upper from src1, flags untouched
    run("R5 mov", 8, 0, 0, 0, 64'h1, 64'hCAFE_0000_0000_1200, 64'h55AA, 6'h3F, 0, 0);
    // R8 condition false (NZ while ZF=1)
    run("R8 cmov false", 8, 3, 0, 0, 64'h77, 64'h1, 64'h2, 6'h3F, 1, 4'h5);
    run("R8 cmov true", 8, 3, 0, 0, 64'h77, 64'h1, 64'h2, 6'h3F, 1, 4'h4);
    run("R8 add gated", 0, 3, 0, 0, 64'h9, 64'h1, 64'h1, 6'h3F, 1, 4'h5);
    // R10 unsupported opcode
    run("R10 bad op", 12, 3, 0, 0, 64'hABCD, 64'h1, 64'h2, 6'h3F, 0, 0);
    // R9 idle cycle
    @(negedge clk);
    chk("R9 idle valid", {63'd0, out_valid}, 0);
    chk("R9 idle flags", {58'd0, flags}, {58'd0, mflags});
    // mixed stream
    for (int i = 0; i < 300; i++) begin
      logic [63:0] x, y, z;
      lfsr = nxt(lfsr); x = lfsr;
      lfsr = nxt(lfsr); y = lfsr;
      lfsr = nxt(lfsr); z = lfsr;
      run("R3 R6 R8 stream", int'(z[3:0]) % 11, int'(z[5:4]), z[6], z[15:8], x,
          (z[7] ? y : {56'd0, y[7:0]}), {x[31:0], y[63:32]}, z[21:16], z[22],
          z[27:24]);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule